// File: doc/BRIEF.md
# Dual-Function PCI Configuration Responder

This block is the configuration-space target of a PCI device that exposes two functions. It takes Type 0 configuration requests that the bus engine has already decoded into a function number, a dword register index, byte enables and write data. It answers only for function 0 and function 1. Both functions share one register layout: identity, command/status, revision/class, cache line size and latency timer, an I/O base register, a memory base register, subsystem identity and a power-management capability. The layout is the same for both functions, but each function keeps its own register state.

Four identity fields are held separately for each function: device ID, class code, subsystem ID and subsystem vendor ID. They are loaded from a nonvolatile image through a simple word-write port before configuration opens. A hardware-configuration word from the same image can switch the device to single-function operation. Until the load is declared complete, every claimed request is answered with a retry. The command bits of each function drive that function's memory-decode, I/O-decode and parity-response enables, which the rest of the chip uses to gate its target logic.

Top module: `pcicfg_dualfn`

## Requirements
- R1: A request is claimed only when `cfgFunc` is 0, or 1 while function 1 is enabled. Values 2 to 7 produce neither acknowledge nor retry, and their writes change no register.
- R2: Until `preloadDone` has been seen, a claimed request gets `cfgRetry` one cycle later and no acknowledge, and its write is discarded. `cfgReady` rises after the done pulse and stays high.
- R3: Preload addresses are {field[1:0], function}, with field 0 = device ID (data[15:0]), 1 = class code (data[23:0]), 2 = subsystem word ({ID, vendor}). Dword 0 reads {device ID of the function, shared vendor ID}, dword 2 bits 31:8 read the function's class code, and dword 11 reads the function's subsystem word.
- R4: Field 3 is the hardware-configuration word. When its bit 0 is 1, bit 23 of dword 3 (multifunction) reads 0 and function 1 is not claimed. When bit 0 is 0, bit 23 reads 1.
- R5: Dword indices with no register, and read-only or unimplemented bits, ignore writes. Unimplemented bits read 0. Dword 1 reads status 0x0010 (capability list present) in its upper half.
- R6: Command bit 0 drives `ioEnable[f]` and bit 1 drives `memEnable[f]`. Writing 0 to the command register clears both, and configuration requests are still acknowledged. The enables are 0 before preload completes and for a disabled function 1.
- R7: Dword 2 bits 7:0 read {4'b0000, `devRev`}.
- R8: The I/O base register (dword 4) implements bits 31:7 and reads bit 0 as 1, so that it requests 128 bytes. The memory base register (dword 5) implements bits 31:12. A write of all ones reads back 0xFFFFFF81 and 0xFFFFF000 respectively.
- R9: Command bit 6 drives `perrRespEn[f]`. It is the only command bit, besides 0, 1 and 2, that can be written.
- R10: `cfgAck` or `cfgRetry` is a single-cycle pulse in the cycle after the request, and the two are never high together. `cfgRdata` carries the read value with a read acknowledge and is 0 at all other times.
- R11: On a write, only the bytes whose `cfgByteEn` bit is 1 change (for example, the cache line size byte 0 and the latency timer byte 1 of dword 3).
- R12: Preload writes that arrive after `preloadDone` are ignored.
- R13: Dword 13 reads the capability pointer 0x40, and dword 16 reads {PM capability word, next pointer 0x00, ID 0x01}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| devRev | input | 4 | Silicon revision shown in the revision ID |
| preloadWe | input | 1 | Image word write strobe |
| preloadAddr | input | 3 | {field, function} of the image word |
| preloadData | input | 32 | Image word |
| preloadDone | input | 1 | Image load complete pulse |
| cfgValid | input | 1 | Configuration request present this cycle |
| cfgWrite | input | 1 | 1 = write, 0 = read |
| cfgFunc | input | 3 | Function number of the request |
| cfgReg | input | 6 | Dword register index |
| cfgByteEn | input | 4 | Byte enables for writes |
| cfgWdata | input | 32 | Write data |
| cfgReady | output | 1 | Preload complete, configuration open |
| cfgAck | output | 1 | Request completed (one cycle after it) |
| cfgRetry | output | 1 | Request must be retried |
| cfgRdata | output | 32 | Read data, valid with a read acknowledge |
| memEnable | output | 2 | Per-function memory decode enable |
| ioEnable | output | 2 | Per-function I/O decode enable |
| perrRespEn | output | 2 | Per-function parity error response enable |

## Verification
The bench targets three kinds of error. The first is writes that leak into places they must not reach. A request to function 2 to 7, a write during the preload window, or a write that drops byte enables would show up as a changed command, base or timer value when that register is read back later. The second is the base-register sizing corner. A design that keeps low address bits writable, or that loses the constant I/O indicator, returns a wrong mask after an all-ones write. The third is the single-function switch. A design that still answers function 1, or still reports the multifunction bit, fails the second preload pass. Randomised traffic over every index, including unused ones, is compared against a model of the register map.

// File: rtl/pcicfg_pkg.sv
package pcicfg_pkg;
  localparam int NUM_FN = 2;
  localparam int REG_IDX_W = 6;

  // dword indices of implemented registers
  localparam logic [5:0] IDX_ID     = 6'd0;
  localparam logic [5:0] IDX_CMD    = 6'd1;
  localparam logic [5:0] IDX_CLASS  = 6'd2;
  localparam logic [5:0] IDX_HDR    = 6'd3;
  localparam logic [5:0] IDX_IOBAR  = 6'd4;
  localparam logic [5:0] IDX_MEMBAR = 6'd5;
  localparam logic [5:0] IDX_SUBSYS = 6'd11;

  // preload field codes (preload address bits 2:1)
  localparam logic [1:0] PF_DEVID  = 2'd0;
  localparam logic [1:0] PF_CLASS  = 2'd1;
  localparam logic [1:0] PF_SUBSYS = 2'd2;
  localparam logic [1:0] PF_HWCFG  = 2'd3;

  typedef struct packed {
    logic                 wr;
    logic                 rd;
    logic                 fn;
    logic [REG_IDX_W-1:0] idx;
    logic [3:0]           be;
    logic                 pre;
    logic [1:0]           preField;
    logic                 preFn;
  } cfg_strobe_t;
endpackage

// File: rtl/pcicfg_ctrl.sv
module pcicfg_ctrl
  import pcicfg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgValid,
  input  logic                 cfgWrite,
  input  logic [2:0]           cfgFunc,
  input  logic [REG_IDX_W-1:0] cfgReg,
  input  logic [3:0]           cfgByteEn,
  input  logic                 preloadWe,
  input  logic [2:0]           preloadAddr,
  input  logic                 preloadDone,
  input  logic                 fn1Enabled,
  output cfg_strobe_t          stb,
  output logic                 cfgReady,
  output logic                 cfgAck,
  output logic                 cfgRetry
);
  logic readyQ, ackQ, retryQ;
  logic claim, fnOk;

  always_comb begin
    fnOk  = (cfgFunc == 3'd0) || ((cfgFunc == 3'd1) && fn1Enabled);
    claim = cfgValid && fnOk;
  end

  always_comb begin
    stb.wr       = claim && readyQ && cfgWrite;
    stb.rd       = claim && readyQ && !cfgWrite;
    stb.fn       = cfgFunc[0];
    stb.idx      = cfgReg;
    stb.be       = cfgByteEn;
    stb.pre      = preloadWe && !readyQ;
    stb.preField = preloadAddr[2:1];
    stb.preFn    = preloadAddr[0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readyQ <= 1'b0;
      ackQ   <= 1'b0;
      retryQ <= 1'b0;
    end else begin
      readyQ <= readyQ | preloadDone;
      ackQ   <= claim && readyQ;
      retryQ <= claim && !readyQ;
    end
  end

  assign cfgReady = readyQ;
  assign cfgAck   = ackQ;
  assign cfgRetry = retryQ;
endmodule

// File: rtl/pcicfg_regs.sv
module pcicfg_regs
  import pcicfg_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID   = 16'h1A2B,
  parameter int          IO_SIZE_LOG2  = 7,
  parameter int          MEM_SIZE_LOG2 = 12,
  parameter logic [15:0] PM_CAPS     = 16'h0002,
  parameter logic [7:0]  CAP_PTR     = 8'h40
)(
  input  logic        clk,
  input  logic        rstN,
  input  cfg_strobe_t stb,
  input  logic [31:0] wdata,
  input  logic [31:0] preData,
  input  logic [3:0]  devRev,
  output logic [31:0] rdata,
  output logic        fn1Enabled,
  output logic [1:0]  memEnable,
  output logic [1:0]  ioEnable,
  output logic [1:0]  perrRespEn
);
  localparam logic [31:0] CMD_WMASK   = 32'h0000_0047;
  localparam logic [31:0] HDR_WMASK   = 32'h0000_FFFF;
  localparam logic [31:0] IOBAR_WMASK = ~((32'd1 << IO_SIZE_LOG2) - 32'd1);
  localparam logic [31:0] MEMBAR_WMASK = ~((32'd1 << MEM_SIZE_LOG2) - 32'd1);
  localparam logic [15:0] STATUS_RO   = 16'h0010;
  localparam logic [5:0]  IDX_CAPPTR  = 6'd13;
  localparam logic [5:0]  IDX_PMCAP   = CAP_PTR[7:2];
  localparam logic [IO_SIZE_LOG2-1:0] IO_LOW = IO_SIZE_LOG2'(1);

  logic [15:0] devIdQ  [NUM_FN];
  logic [23:0] classQ  [NUM_FN];
  logic [31:0] subsysQ [NUM_FN];
  logic [15:0] cmdQ    [NUM_FN];
  logic [15:0] hdrQ    [NUM_FN];
  logic [31:IO_SIZE_LOG2]  ioBarQ  [NUM_FN];
  logic [31:MEM_SIZE_LOG2] memBarQ [NUM_FN];
  logic        singleFnQ;
  logic [1:0]  fnOn;
  logic [31:0] rdMux;
  logic [31:0] rdataQ;

  function automatic logic [31:0] mergeW(input logic [31:0] old, input logic [31:0] wd,
                                          input logic [3:0] be, input logic [31:0] wm);
    logic [31:0] m;
    for (int b = 0; b < 4; b++) m[8*b +: 8] = {8{be[b]}};
    m = m & wm;
    return (old & ~m) | (wd & m);
  endfunction

  assign fnOn       = {~singleFnQ, 1'b1};
  assign fn1Enabled = ~singleFnQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      singleFnQ <= 1'b0;
      for (int f = 0; f < NUM_FN; f++) begin
        devIdQ[f]  <= '0;
        classQ[f]  <= '0;
        subsysQ[f] <= '0;
        cmdQ[f]    <= '0;
        hdrQ[f]    <= '0;
        ioBarQ[f]  <= '0;
        memBarQ[f] <= '0;
      end
    end else begin
      if (stb.pre && stb.preField == PF_HWCFG) singleFnQ <= preData[0];
      for (int f = 0; f < NUM_FN; f++) begin
        if (stb.pre && stb.preFn == f[0]) begin
          case (stb.preField)
            PF_DEVID:  devIdQ[f]  <= preData[15:0];
            PF_CLASS:  classQ[f]  <= preData[23:0];
            PF_SUBSYS: subsysQ[f] <= preData;
            default: ;
          endcase
        end
        if (stb.wr && stb.fn == f[0]) begin
          case (stb.idx)
            IDX_CMD: cmdQ[f] <= 16'(mergeW({16'h0, cmdQ[f]}, wdata, stb.be, CMD_WMASK));
            IDX_HDR: hdrQ[f] <= 16'(mergeW({16'h0, hdrQ[f]}, wdata, stb.be, HDR_WMASK));
            IDX_IOBAR: begin
              logic [31:0] t;
              t = mergeW({ioBarQ[f], {IO_SIZE_LOG2{1'b0}}}, wdata, stb.be, IOBAR_WMASK);
              ioBarQ[f] <= t[31:IO_SIZE_LOG2];
            end
            IDX_MEMBAR: begin
              logic [31:0] t;
              t = mergeW({memBarQ[f], {MEM_SIZE_LOG2{1'b0}}}, wdata, stb.be, MEMBAR_WMASK);
              memBarQ[f] <= t[31:MEM_SIZE_LOG2];
            end
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    rdMux = '0;
    if (stb.idx == IDX_ID)          rdMux = {devIdQ[stb.fn], VENDOR_ID};
    else if (stb.idx == IDX_CMD)    rdMux = {STATUS_RO, cmdQ[stb.fn]};
    else if (stb.idx == IDX_CLASS)  rdMux = {classQ[stb.fn], 4'h0, devRev};
    else if (stb.idx == IDX_HDR)    rdMux = {8'h00, fnOn[1], 7'h00, hdrQ[stb.fn]};
    else if (stb.idx == IDX_IOBAR)  rdMux = {ioBarQ[stb.fn], IO_LOW};
    else if (stb.idx == IDX_MEMBAR) rdMux = {memBarQ[stb.fn], {MEM_SIZE_LOG2{1'b0}}};
    else if (stb.idx == IDX_SUBSYS) rdMux = subsysQ[stb.fn];
    else if (stb.idx == IDX_CAPPTR) rdMux = {24'h0, CAP_PTR};
    else if (stb.idx == IDX_PMCAP)  rdMux = {PM_CAPS, 8'h00, 8'h01};
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdataQ <= '0;
    else       rdataQ <= stb.rd ? rdMux : 32'h0;
  end
  assign rdata = rdataQ;

  for (genvar f = 0; f < NUM_FN; f++) begin : g_en
    assign memEnable[f]  = cmdQ[f][1] & fnOn[f];
    assign ioEnable[f]   = cmdQ[f][0] & fnOn[f];
    assign perrRespEn[f] = cmdQ[f][6] & fnOn[f];
  end
endmodule

// File: rtl/pcicfg_dualfn.sv
module pcicfg_dualfn
  import pcicfg_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID     = 16'h1A2B,
  parameter int          IO_SIZE_LOG2  = 7,
  parameter int          MEM_SIZE_LOG2 = 12,
  parameter logic [15:0] PM_CAPS       = 16'h0002,
  parameter logic [7:0]  CAP_PTR       = 8'h40
)(
  input  logic        clk,
  input  logic        rstN,
  input  logic [3:0]  devRev,
  input  logic        preloadWe,
  input  logic [2:0]  preloadAddr,
  input  logic [31:0] preloadData,
  input  logic        preloadDone,
  input  logic        cfgValid,
  input  logic        cfgWrite,
  input  logic [2:0]  cfgFunc,
  input  logic [5:0]  cfgReg,
  input  logic [3:0]  cfgByteEn,
  input  logic [31:0] cfgWdata,
  output logic        cfgReady,
  output logic        cfgAck,
  output logic        cfgRetry,
  output logic [31:0] cfgRdata,
  output logic [1:0]  memEnable,
  output logic [1:0]  ioEnable,
  output logic [1:0]  perrRespEn
);
  cfg_strobe_t stb;
  logic fn1Enabled;

  pcicfg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgValid(cfgValid), .cfgWrite(cfgWrite), .cfgFunc(cfgFunc),
    .cfgReg(cfgReg), .cfgByteEn(cfgByteEn),
    .preloadWe(preloadWe), .preloadAddr(preloadAddr), .preloadDone(preloadDone),
    .fn1Enabled(fn1Enabled), .stb(stb),
    .cfgReady(cfgReady), .cfgAck(cfgAck), .cfgRetry(cfgRetry)
  );

  pcicfg_regs #(
    .VENDOR_ID(VENDOR_ID), .IO_SIZE_LOG2(IO_SIZE_LOG2),
    .MEM_SIZE_LOG2(MEM_SIZE_LOG2), .PM_CAPS(PM_CAPS), .CAP_PTR(CAP_PTR)
  ) u_regs (
    .clk(clk), .rstN(rstN), .stb(stb), .wdata(cfgWdata),
    .preData(preloadData), .devRev(devRev), .rdata(cfgRdata),
    .fn1Enabled(fn1Enabled), .memEnable(memEnable), .ioEnable(ioEnable),
    .perrRespEn(perrRespEn)
  );
endmodule

// File: rtl/pcicfg_checker.sv
module pcicfg_checker (
  input logic        clk,
  input logic        rstN,
  input logic        cfgValid,
  input logic [2:0]  cfgFunc,
  input logic        cfgReady,
  input logic        cfgAck,
  input logic        cfgRetry,
  input logic [31:0] cfgRdata,
  input logic [1:0]  memEnable,
  input logic [1:0]  ioEnable
);
  AST_BAD_FUNC_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    cfgValid && cfgFunc[2:1] != 2'b00 |=> !cfgAck && !cfgRetry); // R1
  AST_FN0_ANSWERED: assert property (@(posedge clk) disable iff (!rstN)
    cfgValid && cfgFunc == 3'd0 |=> cfgAck || cfgRetry); // R10
  AST_NO_ACK_WHILE_LOADING: assert property (@(posedge clk) disable iff (!rstN)
    cfgValid && !cfgReady |=> !cfgAck); // R2
  AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    cfgReady |=> cfgReady); // R2
  AST_ACK_RETRY_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgAck && cfgRetry)); // R10
  AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !cfgAck |-> cfgRdata == 32'h0); // R10
  AST_ENABLES_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    !cfgReady |-> memEnable == 2'b00 && ioEnable == 2'b00); // R6
endmodule

bind pcicfg_dualfn pcicfg_checker u_chk (.*);

// File: tb/sim_pcicfg_dualfn.sv
module sim_pcicfg_dualfn;
  logic        clk = 0;
  logic        rstN = 0;
  logic [3:0]  devRev = 4'h9;
  logic        preloadWe = 0;
  logic [2:0]  preloadAddr = 0;
  logic [31:0] preloadData = 0;
  logic        preloadDone = 0;
  logic        cfgValid = 0, cfgWrite = 0;
  logic [2:0]  cfgFunc = 0;
  logic [5:0]  cfgReg = 0;
  logic [3:0]  cfgByteEn = 0;
  logic [31:0] cfgWdata = 0;
  logic        cfgReady, cfgAck, cfgRetry;
  logic [31:0] cfgRdata;
  logic [1:0]  memEnable, ioEnable, perrRespEn;

  always #10 clk = ~clk;

  pcicfg_dualfn u0 (.*);

  int nRun = 0, nFail = 0;
  logic        gotAck, gotRetry;
  logic [31:0] gotData;

  // bench model
  localparam logic [15:0] VID = 16'h1A2B;
  logic [15:0] mDev [2];
  logic [23:0] mClass [2];
  logic [31:0] mSub [2];
  logic [31:0] mCmd [2], mHdr [2], mIo [2], mMem [2];
  logic        mSingle;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] wmask(logic [5:0] idx);
    case (idx)
      6'd1: return 32'h0000_0047;
      6'd3: return 32'h0000_FFFF;
      6'd4: return 32'hFFFF_FF80;
      6'd5: return 32'hFFFF_F000;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] expRead(int f, logic [5:0] idx);
    case (idx)
      6'd0:  return {mDev[f], VID};
      6'd1:  return {16'h0010, mCmd[f][15:0]};
      6'd2:  return {mClass[f], 4'h0, devRev};
      6'd3:  return {8'h00, ~mSingle, 7'h00, mHdr[f][15:0]};
      6'd4:  return mIo[f] | 32'h1;
      6'd5:  return mMem[f];
      6'd11: return mSub[f];
      6'd13: return 32'h40;
      6'd16: return {16'h0002, 8'h00, 8'h01};
      default: return 32'h0;
    endcase
  endfunction

  task automatic modelWrite(int f, logic [5:0] idx, logic [3:0] be, logic [31:0] wd);
    logic [31:0] m;
    for (int b = 0; b < 4; b++) m[8*b +: 8] = {8{be[b]}};
    m = m & wmask(idx);
    case (idx)
      6'd1: mCmd[f] = (mCmd[f] & ~m) | (wd & m);
      6'd3: mHdr[f] = (mHdr[f] & ~m) | (wd & m);
      6'd4: mIo[f]  = (mIo[f] & ~m) | (wd & m);
      6'd5: mMem[f] = (mMem[f] & ~m) | (wd & m);
      default: ;
    endcase
  endtask

  task automatic modelReset();
    for (int f = 0; f < 2; f++) begin
      mDev[f] = 0; mClass[f] = 0; mSub[f] = 0;
      mCmd[f] = 0; mHdr[f] = 0; mIo[f] = 0; mMem[f] = 0;
    end
    mSingle = 0;
  endtask

  task automatic doCfg(logic wr, logic [2:0] fn, logic [5:0] idx, logic [3:0] be, logic [31:0] wd);
    @(negedge clk);
    cfgValid = 1; cfgWrite = wr; cfgFunc = fn; cfgReg = idx; cfgByteEn = be; cfgWdata = wd;
    @(negedge clk);
    cfgValid = 0;
    gotAck = cfgAck; gotRetry = cfgRetry; gotData = cfgRdata;
  endtask

  task automatic preload(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    preloadWe = 1; preloadAddr = a; preloadData = d;
    @(negedge clk);
    preloadWe = 0;
  endtask

  task automatic finishLoad();
    @(negedge clk); preloadDone = 1;
    @(negedge clk); preloadDone = 0;
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 0;
    repeat (2) @(negedge clk);
    rstN = 1;
    modelReset();
  endtask

  task automatic chkEnables(string req);
    logic [1:0] en;
    for (int f = 0; f < 2; f++) en[f] = ~(mSingle && f == 1);
    chk({req, " memEnable"}, {30'h0, memEnable}, {30'h0, {mCmd[1][1], mCmd[0][1]} & en});
    chk({req, " ioEnable"}, {30'h0, ioEnable}, {30'h0, {mCmd[1][0], mCmd[0][0]} & en});
    chk({req, " perrRespEn"}, {30'h0, perrRespEn}, {30'h0, {mCmd[1][6], mCmd[0][6]} & en});
  endtask

  task automatic readChk(string req, int f, logic [5:0] idx);
    doCfg(0, 3'(f), idx, 4'hF, 32'h0);
    chk({req, " ack"}, {31'h0, gotAck}, 32'h1);
    chk({req, " data"}, gotData, expRead(f, idx));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    doReset();
    @(negedge clk);
    chk("R2 ready at reset", {31'h0, cfgReady}, 32'h0);
    chk("R6 enables at reset", {28'h0, memEnable, ioEnable}, 32'h0);

    // requests during preload window
    doCfg(0, 3'd0, 6'd0, 4'hF, 0);
    chk("R2 retry before load", {30'h0, gotAck, gotRetry}, 32'h1);
    doCfg(1, 3'd0, 6'd1, 4'hF, 32'h3);
    chk("R2 write retried", {30'h0, gotAck, gotRetry}, 32'h1);
    chk("R6 enables after early write", {28'h0, memEnable, ioEnable}, 32'h0);

    preload(3'b000, 32'h0000_0B01); mDev[0] = 16'h0B01;
    preload(3'b001, 32'h0000_0B02); mDev[1] = 16'h0B02;
    preload(3'b010, 32'h0001_0400); mClass[0] = 24'h010400;
    preload(3'b011, 32'h0002_0000); mClass[1] = 24'h020000;
    preload(3'b100, 32'h5555_AAAA); mSub[0] = 32'h5555_AAAA;
    preload(3'b101, 32'h1234_5678); mSub[1] = 32'h1234_5678;
    preload(3'b110, 32'h0);
    finishLoad();
    chk("R2 ready after done", {31'h0, cfgReady}, 32'h1);
    preload(3'b000, 32'h0000_DEAD);  // late write, must be ignored

    readChk("R12 late preload ignored", 0, 6'd0);
    readChk("R3 fn1 identity", 1, 6'd0);
    readChk("R3 fn0 class", 0, 6'd2);
    readChk("R3 fn1 subsys", 1, 6'd11);
    readChk("R3 fn0 subsys", 0, 6'd11);
    readChk("R2 early write discarded", 0, 6'd1);
    readChk("R4 multifunction bit set", 0, 6'd3);
    readChk("R13 capability pointer", 0, 6'd13);
    readChk("R13 PM capability", 1, 6'd16);
    devRev = 4'h3;
    readChk("R7 revision follows input", 1, 6'd2);

    for (int fn = 2; fn < 8; fn++) begin
      doCfg(1, 3'(fn), 6'd1, 4'hF, 32'hFFFF_FFFF);
      chk("R1 bad function silent", {30'h0, gotAck, gotRetry}, 32'h0);
    end
    chkEnables("R1 bad function no effect");
    readChk("R1 command untouched", 0, 6'd1);

    // base register sizing
    doCfg(1, 3'd0, 6'd4, 4'hF, 32'hFFFF_FFFF); modelWrite(0, 6'd4, 4'hF, 32'hFFFF_FFFF);
    doCfg(0, 3'd0, 6'd4, 4'hF, 0);
    chk("R8 io base sizing", gotData, 32'hFFFF_FF81);
    doCfg(1, 3'd1, 6'd5, 4'hF, 32'hFFFF_FFFF); modelWrite(1, 6'd5, 4'hF, 32'hFFFF_FFFF);
    doCfg(0, 3'd1, 6'd5, 4'hF, 0);
    chk("R8 mem base sizing", gotData, 32'hFFFF_F000);

    // byte enables
    doCfg(1, 3'd0, 6'd3, 4'b0001, 32'h0000_4020); modelWrite(0, 6'd3, 4'b0001, 32'h0000_4020);
    doCfg(0, 3'd0, 6'd3, 4'hF, 0);
    chk("R11 only byte 0 written", gotData, 32'h0080_0020);

    // command
    doCfg(1, 3'd0, 6'd1, 4'hF, 32'hFFFF_FFFF); modelWrite(0, 6'd1, 4'hF, 32'hFFFF_FFFF);
    chk("R9 perr enable fn0", {30'h0, perrRespEn}, 32'h1);
    chk("R6 enables fn0", {28'h0, memEnable, ioEnable}, 32'h5);
    doCfg(0, 3'd0, 6'd1, 4'hF, 0);
    chk("R5 command readback masked", gotData, 32'h0010_0047);
    doCfg(1, 3'd0, 6'd1, 4'hF, 0); modelWrite(0, 6'd1, 4'hF, 0);
    chk("R6 zero command acked", {31'h0, gotAck}, 32'h1);
    chk("R6 zero command clears", {28'h0, memEnable, ioEnable}, 32'h0);
    doCfg(1, 3'd0, 6'd20, 4'hF, 32'hFFFF_FFFF);
    doCfg(0, 3'd0, 6'd20, 4'hF, 0);
    chk("R5 unused dword reads zero", gotData, 32'h0);

    // randomised traffic
    for (int i = 0; i < 400; i++) begin
      int r, k;
      logic [2:0] fn; logic [5:0] idx; logic wr; logic [3:0] be; logic [31:0] wd;
      r = int'($urandom % 8);
      fn = (r < 6) ? 3'(r % 2) : 3'(r);
      k = int'($urandom % 20);
      idx = (k < 18) ? 6'(k) : 6'($urandom % 64);
      wr = 1'($urandom % 2); be = 4'($urandom % 16); wd = $urandom;
      doCfg(wr, fn, idx, be, wd);
      if (fn > 1) begin
        chk("R1 random bad function", {30'h0, gotAck, gotRetry}, 32'h0);
      end else begin
        chk("R10 random ack", {30'h0, gotAck, gotRetry}, 32'h2);
        if (wr) begin
          modelWrite(int'(fn), idx, be, wd);
          chk("R10 rdata zero on write", gotData, 32'h0);
        end else begin
          chk("R5 random read", gotData, expRead(int'(fn), idx));
        end
      end
      chkEnables("R6 random");
    end

    // single-function image
    doReset();
    preload(3'b000, 32'h0000_0C01); mDev[0] = 16'h0C01;
    preload(3'b111, 32'h0000_0001); mSingle = 1;
    finishLoad();
    doCfg(0, 3'd1, 6'd0, 4'hF, 0);
    chk("R4 fn1 not claimed", {30'h0, gotAck, gotRetry}, 32'h0);
    doCfg(1, 3'd1, 6'd1, 4'hF, 32'h3);
    chk("R4 fn1 write ignored", {30'h0, ioEnable[1], memEnable[1]}, 32'h0);
    readChk("R4 multifunction bit clear", 0, 6'd3);
    readChk("R3 fn0 identity after reload", 0, 6'd0);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule